// File: doc/BRIEF.md
# Queued Command Tag Context Tracker

This block keeps the bookkeeping for up to 32 queued disk commands that may be in flight at once. Host logic stores one descriptor-table pointer per command tag and announces each command it issues. The drive then decides on its own which queued command a data transfer belongs to. Decoded frame events reach the block as plain inputs: a DMA-setup event carrying a tag, a set-device-bits event carrying a completion field with one bit per tag, and an error indication.

When a DMA-setup event names a tag that is outstanding, the block looks up that tag's pointer and presents it, with the tag, to the DMA engine as a one-cycle strobe. No software step is involved. Completions clear outstanding bits. A drive busy flag plays no part in this, because it only signals readiness for a new command. When the drive reports an error, all context selection and completion processing stop. The outstanding set stays frozen for inspection until a restart input is asserted.

Top module: `qtag_ctx_tracker`

## Requirements
- R1: After reset, `outstanding` is all zero, `ctx_valid`, `halted` and `proto_err` are low, and every stored pointer is zero.
- R2: An issue of tag n (`issue_en` high, `issue_tag`=n) while not halted and with no `dev_error` sets bit n of `outstanding` on the next clock. Other bits are unchanged.
- R3: An accepted set-device-bits event clears every `outstanding` bit n for which bit n of `sdb_done` is 1. If the same tag is issued and completed in the same cycle, the completion wins and the bit ends up 0.
- R4: `ptr_wr_en` stores `ptr_wr_data` for tag `ptr_wr_tag`, indexed directly by the tag. Writes are accepted even while halted.
- R5: An accepted DMA-setup event for an outstanding tag n raises `ctx_valid` for exactly one cycle, one clock later. In that cycle `ctx_tag`=n and `ctx_ptr` holds the pointer stored for n before the event's cycle.
- R6: A DMA-setup event for a tag whose `outstanding` bit is 0 produces no `ctx_valid`. It sets `proto_err` on the next clock. `proto_err` stays high until `perr_clear`, and a new error in the same cycle as the clear keeps it high.
- R7: `dev_error` sets `halted` on the next clock. Events in the error cycle itself are ignored. While halted, DMA-setup, set-device-bits and issue inputs have no effect: no `ctx_valid`, no `proto_err`, and `outstanding` stays unchanged.
- R8: `restart` clears `halted` on the next clock. If `dev_error` is asserted in the same cycle, the block stays halted.
- R9: A DMA-setup event does not change `outstanding`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptr_wr_en | input | 1 | Store a descriptor-table pointer |
| ptr_wr_tag | input | TAG_W (5) | Tag whose pointer is written |
| ptr_wr_data | input | PTR_W (32) | Pointer value |
| issue_en | input | 1 | Host issues a queued command |
| issue_tag | input | TAG_W (5) | Tag of the issued command |
| dsetup_valid | input | 1 | DMA-setup event from the drive |
| dsetup_tag | input | TAG_W (5) | Tag named by the DMA-setup event |
| sdb_valid | input | 1 | Set-device-bits event |
| sdb_done | input | NUM_TAGS (32) | Completion field, bit n = tag n |
| dev_error | input | 1 | Drive reported a failed command |
| restart | input | 1 | Explicit restart after an error |
| perr_clear | input | 1 | Clear the sticky protocol-error flag |
| ctx_valid | output | 1 | One-cycle context-load strobe |
| ctx_tag | output | TAG_W (5) | Tag of the loaded context |
| ctx_ptr | output | PTR_W (32) | Pointer of the loaded context |
| outstanding | output | NUM_TAGS (32) | Outstanding command bits |
| halted | output | 1 | Processing stopped after an error |
| proto_err | output | 1 | Sticky DMA-setup-for-idle-tag flag |

## Verification
A corrupted outstanding bit shows up on `outstanding` in the cycle right after the update that caused it. It also shows up one clock after a DMA-setup event for that tag, either as a missing `ctx_valid` with `proto_err` rising, or as a strobe where none should be. A wrong pointer-table entry stays hidden until a DMA-setup event selects that tag, so the bench sweeps every tag with a distinct pointer. A halt flag stuck in the wrong state is seen one clock after the next event, through a frozen or moving `outstanding` and through `ctx_valid`.

// File: rtl/qtag_pkg.sv
`timescale 1ns/1ps
package qtag_pkg;
   typedef enum logic {
      RUN_ACTIVE = 1'b0,
      RUN_HALTED = 1'b1
   } run_state_e;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/qtag_ptr_table.sv
`timescale 1ns/1ps
module qtag_ptr_table #(
   parameter int NUM_TAGS    = 32,
   parameter int PTR_W       = 32,
   parameter int TAG_W       = 5,
   parameter bit ANDOR_READ  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [TAG_W-1:0] wr_tag,
   input  logic [PTR_W-1:0] wr_data,
   input  logic [TAG_W-1:0] rd_tag,
   output logic [PTR_W-1:0] rd_data
);
   logic [PTR_W-1:0] entry [NUM_TAGS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_TAGS; i++) entry[i] <= '0;
      end else if (wr_en) begin
         entry[wr_tag] <= wr_data;
      end
   end

   if (ANDOR_READ) begin : g_andor
      always_comb begin
         rd_data = '0;
         for (int i = 0; i < NUM_TAGS; i++) begin
            rd_data = rd_data | (entry[i] & {PTR_W{rd_tag == TAG_W'(i)}});
         end
      end
   end else begin : g_index
      assign rd_data = entry[rd_tag];
   end
endmodule

// File: rtl/qtag_pending.sv
`timescale 1ns/1ps
module qtag_pending #(
   parameter int NUM_TAGS = 32,
   parameter int TAG_W    = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                set_en,
   input  logic [TAG_W-1:0]    set_tag,
   input  logic                clr_en,
   input  logic [NUM_TAGS-1:0] clr_mask,
   output logic [NUM_TAGS-1:0] pend
);
   logic [NUM_TAGS-1:0] pend_nxt;

   for (genvar i = 0; i < NUM_TAGS; i++) begin : g_bit
      logic hit_set;
      logic hit_clr;
      assign hit_set     = set_en && (set_tag == TAG_W'(i));
      assign hit_clr     = clr_en && clr_mask[i];
      assign pend_nxt[i] = hit_clr ? 1'b0 : (hit_set ? 1'b1 : pend[i]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) pend <= '0;
      else        pend <= pend_nxt;
   end
endmodule

// File: rtl/qtag_run_ctl.sv
`timescale 1ns/1ps
module qtag_run_ctl
   import qtag_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic dev_error,
   input  logic restart,
   input  logic setup_req,
   input  logic setup_hit,
   input  logic sdb_req,
   input  logic issue_req,
   input  logic perr_clear,
   output logic accept_setup,
   output logic accept_sdb,
   output logic accept_issue,
   output logic halted,
   output logic proto_err
);
   run_state_e state_q, state_d;
   logic       active;
   logic       bad_setup;
   logic       perr_q;

   assign active       = (state_q == RUN_ACTIVE) && !dev_error;
   assign accept_setup = active && setup_req && setup_hit;
   assign bad_setup    = active && setup_req && !setup_hit;
   assign accept_sdb   = active && sdb_req;
   assign accept_issue = active && issue_req;

   always_comb begin
      state_d = state_q;
      if (dev_error)    state_d = RUN_HALTED;
      else if (restart) state_d = RUN_ACTIVE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= RUN_ACTIVE;
         perr_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         if (bad_setup)       perr_q <= 1'b1;
         else if (perr_clear) perr_q <= 1'b0;
      end
   end

   assign halted    = (state_q == RUN_HALTED);
   assign proto_err = perr_q;
endmodule

// File: rtl/qtag_ctx_tracker.sv
`timescale 1ns/1ps
module qtag_ctx_tracker #(
   parameter int NUM_TAGS   = 32,
   parameter int PTR_W      = 32,
   parameter bit ANDOR_READ = 1'b1,
   localparam int TAG_W     = (NUM_TAGS > 1) ? $clog2(NUM_TAGS) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ptr_wr_en,
   input  logic [TAG_W-1:0]    ptr_wr_tag,
   input  logic [PTR_W-1:0]    ptr_wr_data,
   input  logic                issue_en,
   input  logic [TAG_W-1:0]    issue_tag,
   input  logic                dsetup_valid,
   input  logic [TAG_W-1:0]    dsetup_tag,
   input  logic                sdb_valid,
   input  logic [NUM_TAGS-1:0] sdb_done,
   input  logic                dev_error,
   input  logic                restart,
   input  logic                perr_clear,
   output logic                ctx_valid,
   output logic [TAG_W-1:0]    ctx_tag,
   output logic [PTR_W-1:0]    ctx_ptr,
   output logic [NUM_TAGS-1:0] outstanding,
   output logic                halted,
   output logic                proto_err
);
   if (NUM_TAGS < 2 || NUM_TAGS > 32) begin : g_bad_tags
      $error("qtag_ctx_tracker: NUM_TAGS must lie in 2..32");
   end
   if (!qtag_pkg::is_pow2(NUM_TAGS)) begin : g_bad_pow2
      $error("qtag_ctx_tracker: NUM_TAGS must be a power of two");
   end
   if (PTR_W < 8 || PTR_W > 64) begin : g_bad_ptr
      $error("qtag_ctx_tracker: PTR_W must lie in 8..64");
   end

   logic             accept_setup;
   logic             accept_sdb;
   logic             accept_issue;
   logic             setup_hit;
   logic [PTR_W-1:0] lookup_ptr;

   assign setup_hit = outstanding[dsetup_tag];

   qtag_run_ctl u_run (
      .clk          (clk),
      .rst_n        (rst_n),
      .dev_error    (dev_error),
      .restart      (restart),
      .setup_req    (dsetup_valid),
      .setup_hit    (setup_hit),
      .sdb_req      (sdb_valid),
      .issue_req    (issue_en),
      .perr_clear   (perr_clear),
      .accept_setup (accept_setup),
      .accept_sdb   (accept_sdb),
      .accept_issue (accept_issue),
      .halted       (halted),
      .proto_err    (proto_err)
   );

   qtag_pending #(.NUM_TAGS(NUM_TAGS), .TAG_W(TAG_W)) u_pend (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_en   (accept_issue),
      .set_tag  (issue_tag),
      .clr_en   (accept_sdb),
      .clr_mask (sdb_done),
      .pend     (outstanding)
   );

   qtag_ptr_table #(
      .NUM_TAGS   (NUM_TAGS),
      .PTR_W      (PTR_W),
      .TAG_W      (TAG_W),
      .ANDOR_READ (ANDOR_READ)
   ) u_tbl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (ptr_wr_en),
      .wr_tag  (ptr_wr_tag),
      .wr_data (ptr_wr_data),
      .rd_tag  (dsetup_tag),
      .rd_data (lookup_ptr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctx_valid <= 1'b0;
         ctx_tag   <= '0;
         ctx_ptr   <= '0;
      end else begin
         ctx_valid <= accept_setup;
         if (accept_setup) begin
            ctx_tag <= dsetup_tag;
            ctx_ptr <= lookup_ptr;
         end
      end
   end
endmodule

// File: rtl/qtag_ctx_tracker_chk.sv
`timescale 1ns/1ps
module qtag_ctx_tracker_chk #(
   parameter int NUM_TAGS = 32,
   parameter int TAG_W    = 5
) (
   input logic                clk,
   input logic                rst_n,
   input logic                issue_en,
   input logic                dsetup_valid,
   input logic                sdb_valid,
   input logic [NUM_TAGS-1:0] sdb_done,
   input logic                dev_error,
   input logic                restart,
   input logic                perr_clear,
   input logic                ctx_valid,
   input logic [TAG_W-1:0]    ctx_tag,
   input logic [NUM_TAGS-1:0] outstanding,
   input logic                halted,
   input logic                proto_err
);
   logic [NUM_TAGS-1:0] out_q;
   always_ff @(posedge clk) begin
      if (!rst_n) out_q <= '0;
      else        out_q <= outstanding;
   end

   AST_CTX_ONLY_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
      ctx_valid |-> out_q[ctx_tag]); // R5
   AST_CTX_NEEDS_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
      ctx_valid |-> $past(dsetup_valid)); // R5
   AST_SDB_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (sdb_valid && !halted && !dev_error) |=> ((outstanding & $past(sdb_done)) == '0)); // R3
   AST_PERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (proto_err && !perr_clear) |=> proto_err); // R6
   AST_ERR_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
      dev_error |=> halted); // R7
   AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> $stable(outstanding)); // R7
   AST_HALT_NO_CTX: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> !ctx_valid); // R7
   AST_RESTART_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
      (restart && !dev_error) |=> !halted); // R8
   AST_SETUP_KEEPS_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (dsetup_valid && !issue_en && !sdb_valid) |=> $stable(outstanding)); // R9
endmodule

bind qtag_ctx_tracker qtag_ctx_tracker_chk #(.NUM_TAGS(NUM_TAGS), .TAG_W(TAG_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .issue_en     (issue_en),
   .dsetup_valid (dsetup_valid),
   .sdb_valid    (sdb_valid),
   .sdb_done     (sdb_done),
   .dev_error    (dev_error),
   .restart      (restart),
   .perr_clear   (perr_clear),
   .ctx_valid    (ctx_valid),
   .ctx_tag      (ctx_tag),
   .outstanding  (outstanding),
   .halted       (halted),
   .proto_err    (proto_err)
);

// File: tb/qtag_ctx_tracker_test.sv
`timescale 1ns/1ps
module qtag_ctx_tracker_test;
   localparam int NT = 32;
   localparam int PW = 32;
   localparam int TW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ptr_wr_en, issue_en, dsetup_valid, sdb_valid;
   logic          dev_error, restart, perr_clear;
   logic [TW-1:0] ptr_wr_tag, issue_tag, dsetup_tag;
   logic [PW-1:0] ptr_wr_data;
   logic [NT-1:0] sdb_done;
   logic          ctx_valid, halted, proto_err;
   logic [TW-1:0] ctx_tag;
   logic [PW-1:0] ctx_ptr;
   logic [NT-1:0] outstanding;

   int            n_chk = 0;
   int            n_fail = 0;
   logic [NT-1:0] exp_out = '0;

   always #2.5 clk = ~clk;

   qtag_ctx_tracker uut (
      .clk(clk), .rst_n(rst_n),
      .ptr_wr_en(ptr_wr_en), .ptr_wr_tag(ptr_wr_tag), .ptr_wr_data(ptr_wr_data),
      .issue_en(issue_en), .issue_tag(issue_tag),
      .dsetup_valid(dsetup_valid), .dsetup_tag(dsetup_tag),
      .sdb_valid(sdb_valid), .sdb_done(sdb_done),
      .dev_error(dev_error), .restart(restart), .perr_clear(perr_clear),
      .ctx_valid(ctx_valid), .ctx_tag(ctx_tag), .ctx_ptr(ctx_ptr),
      .outstanding(outstanding), .halted(halted), .proto_err(proto_err)
   );

   function automatic logic [PW-1:0] ptr_of(input int n);
      return 32'hC000_0000 + 32'(n) * 32'h0001_0111;
   endfunction

   task automatic idle();
      ptr_wr_en = 0; issue_en = 0; dsetup_valid = 0; sdb_valid = 0;
      dev_error = 0; restart = 0; perr_clear = 0;
      ptr_wr_tag = '0; issue_tag = '0; dsetup_tag = '0; ptr_wr_data = '0; sdb_done = '0;
   endtask

   task automatic tick();
      @(posedge clk); #1;
      idle();
   endtask

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic do_issue(input int t);
      issue_en = 1; issue_tag = TW'(t); tick();
   endtask

   task automatic do_sdb(input logic [NT-1:0] m);
      sdb_valid = 1; sdb_done = m; tick();
   endtask

   task automatic do_ptr(input int t, input logic [PW-1:0] p);
      ptr_wr_en = 1; ptr_wr_tag = TW'(t); ptr_wr_data = p; tick();
   endtask

   task automatic do_setup(input int t);
      dsetup_valid = 1; dsetup_tag = TW'(t); tick();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=expired expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      idle();
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      chk(outstanding == '0, "R1", "outstanding", 64'(outstanding), 0);
      chk(!ctx_valid && !halted && !proto_err, "R1", "flags",
          {61'b0, ctx_valid, halted, proto_err}, 0);

      // R1: unwritten pointer reads as zero
      do_issue(3); exp_out[3] = 1;
      do_setup(3);
      chk(ctx_valid && ctx_tag == 3 && ctx_ptr == 0, "R1", "zero pointer", 64'(ctx_ptr), 0);
      do_sdb(32'h8); exp_out[3] = 0;

      // R4: fill the table; R2: issue every tag
      for (int t = 0; t < NT; t++) do_ptr(t, ptr_of(t));
      for (int t = 0; t < NT; t++) begin
         do_issue(t); exp_out[t] = 1;
         chk(outstanding == exp_out, "R2", "issue sweep", 64'(outstanding), 64'(exp_out));
      end

      // R5/R9: setup every tag in reverse order
      for (int t = NT - 1; t >= 0; t--) begin
         do_setup(t);
         chk(ctx_valid == 1, "R5", "strobe", 64'(ctx_valid), 1);
         chk(ctx_tag == TW'(t) && ctx_ptr == ptr_of(t), "R4", "context ptr",
             64'(ctx_ptr), 64'(ptr_of(t)));
         chk(outstanding == exp_out, "R9", "setup keeps set", 64'(outstanding), 64'(exp_out));
         tick();
         chk(ctx_valid == 0, "R5", "single pulse", 64'(ctx_valid), 0);
      end

      // R5: back-to-back setups give strobes in consecutive cycles
      dsetup_valid = 1; dsetup_tag = 5'd9; tick();
      dsetup_valid = 1; dsetup_tag = 5'd22;
      chk(ctx_valid && ctx_tag == 9, "R5", "b2b first", 64'(ctx_tag), 9);
      tick();
      chk(ctx_valid && ctx_tag == 22 && ctx_ptr == ptr_of(22), "R5", "b2b second",
          64'(ctx_ptr), 64'(ptr_of(22)));

      // R3: completion patterns
      begin
         logic [NT-1:0] pats [4];
         pats[0] = 32'h0000_0001; pats[1] = 32'h5555_0000;
         pats[2] = 32'h0F0F_F0F0; pats[3] = 32'hFFFF_FFFF;
         for (int i = 0; i < 4; i++) begin
            do_sdb(pats[i]); exp_out = exp_out & ~pats[i];
            chk(outstanding == exp_out, "R3", "completion mask", 64'(outstanding), 64'(exp_out));
         end
      end

      // R3: same-cycle issue and completion
      do_issue(7); exp_out[7] = 1;
      issue_en = 1; issue_tag = 5'd7; sdb_valid = 1; sdb_done = 32'h80; tick();
      exp_out[7] = 0;
      chk(outstanding == exp_out, "R3", "completion wins", 64'(outstanding), 64'(exp_out));
      do_issue(7); exp_out[7] = 1;
      issue_en = 1; issue_tag = 5'd8; sdb_valid = 1; sdb_done = 32'h80; tick();
      exp_out[7] = 0; exp_out[8] = 1;
      chk(outstanding == exp_out, "R3", "other tag issue", 64'(outstanding), 64'(exp_out));

      // R6: setup for idle tag
      do_setup(7);
      chk(!ctx_valid, "R6", "no strobe on idle tag", 64'(ctx_valid), 0);
      chk(proto_err, "R6", "perr set", 64'(proto_err), 1);
      tick(); tick();
      chk(proto_err, "R6", "perr sticky", 64'(proto_err), 1);
      perr_clear = 1; dsetup_valid = 1; dsetup_tag = 5'd30; tick();
      chk(proto_err, "R6", "set beats clear", 64'(proto_err), 1);
      perr_clear = 1; tick();
      chk(!proto_err, "R6", "perr cleared", 64'(proto_err), 0);

      // R7: error halts; event in the error cycle is ignored
      do_issue(12); exp_out[12] = 1;
      dev_error = 1; dsetup_valid = 1; dsetup_tag = 5'd12; tick();
      chk(halted && !ctx_valid, "R7", "halt and no strobe",
          {62'b0, halted, ctx_valid}, 64'h2);
      do_issue(20);
      do_sdb('1);
      do_setup(21);
      chk(!ctx_valid && !proto_err, "R7", "halted setup ignored",
          {62'b0, ctx_valid, proto_err}, 0);
      do_setup(12);
      chk(!ctx_valid, "R7", "halted valid setup ignored", 64'(ctx_valid), 0);
      chk(outstanding == exp_out, "R7", "frozen outstanding", 64'(outstanding), 64'(exp_out));
      do_ptr(12, 32'h1234_5678);

      // R8: restart
      restart = 1; dev_error = 1; tick();
      chk(halted, "R8", "error beats restart", 64'(halted), 1);
      restart = 1; tick();
      chk(!halted, "R8", "restart resumes", 64'(halted), 0);
      do_setup(12);
      chk(ctx_valid && ctx_ptr == 32'h1234_5678, "R4", "write while halted kept",
          64'(ctx_ptr), 64'h1234_5678);
      do_issue(20); exp_out[20] = 1;
      chk(outstanding == exp_out, "R8", "issue after restart", 64'(outstanding), 64'(exp_out));

      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule